// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block is the read side of an SDRAM controller for a bank that is already open. When it gets a start strobe, it puts a READ for the given bank and column on the command bus. It then fills every following cycle with NOP while the data comes back. If fewer words are wanted than the burst would deliver, it stops the burst early. It does this by placing either a BURST TERMINATE or a single-bank PRECHARGE at the cycle that lets the last wanted word arrive and no word after it.

The CAS latency can be 2 or 3 and the burst can be fixed-length or full-page. A command is sent CL-1 cycles before the edge it acts on, and the first word lands CL cycles after READ. The result is that the terminating command always falls N cycles after READ, where N is the effective word count, whatever the latency. A capture strobe marks each wanted word. A one-cycle done pulse follows the last one, and a new start is taken in that same cycle.

Top module: `sdram_rd_trunc`

## Requirements
- R1: In reset and while idle, the command bus carries NOP (`{cs_n,ras_n,cas_n,we_n}` = 4'b0111). In those states DQM is high, and capture, done and busy are low.
- R2: A start sampled while idle (or in the done cycle) puts READ (4'b0101) on the bus in the next cycle. In that cycle, addr[COL_W-1:0] holds the column, ba holds the bank, and addr[AP_BIT] holds the auto-precharge flag. The flag is forced to 0 in full-page mode. All other address bits are 0.
- R3: The effective count N is set as follows. A word count of 0 counts as 1. In full-page mode N is the word count. In fixed mode with auto precharge, N is FIXED_BL. Otherwise N is the smaller of the word count and FIXED_BL.
- R4: capture is high for exactly N consecutive cycles, starting CL cycles after the READ cycle. CL is 2 when cas_lat is 0 and 3 when cas_lat is 1.
- R5: A terminating command is issued when the burst is full-page, or when N < FIXED_BL. It is issued exactly N cycles after READ, for either latency.
- R6: The terminating command is BURST TERMINATE (4'b0110) when use_pre is 0. It is PRECHARGE (4'b0010) when use_pre is 1, with ba equal to the bank and addr all zero (A10 low, so a single bank).
- R7: A fixed-length burst with auto precharge never gets a terminating command. It runs all FIXED_BL words.
- R8: Every cycle other than READ and the terminating command carries NOP.
- R9: DQM is low from the READ cycle through the done cycle.
- R10: done is high for exactly one cycle, the cycle after the last capture. busy is high from READ up to, but not including, that cycle.
- R11: A start while busy is ignored. A start in the done cycle is accepted, and its READ follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a read sequence |
| bank | input | BA_W | Bank address |
| col | input | COL_W | Starting column |
| word_cnt | input | CNT_W | Number of words wanted |
| cas_lat | input | 1 | 0: CL=2, 1: CL=3 |
| full_page | input | 1 | Full-page burst mode |
| auto_pre | input | 1 | Auto precharge on the READ |
| use_pre | input | 1 | Truncate with PRECHARGE instead of BURST TERMINATE |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| addr | output | ADDR_W | SDRAM address bus |
| ba | output | BA_W | SDRAM bank address |
| dqm | output | 1 | Data mask (low = drive) |
| capture | output | 1 | Wanted word valid on DQ this cycle |
| done | output | 1 | One-cycle end pulse |
| busy | output | 1 | Sequence in progress, start ignored |

## Verification
Two pairs of functions can land in the same cycle. First, the terminating command and a capture overlap whenever N > CL. Short counts such as N=1 at CL=3 instead put the command before any data. Second, done and the acceptance of a new start fall together when start is held high across the end of a sequence. The bench provokes both through its choice of counts and by holding start high. A behavioural model predicts, for every cycle, the command, address, capture, done, busy and DQM, and compares them all on every clock.

// File: rtl/sdram_rd_trunc.sv
module sdram_rd_trunc #(
  parameter int BA_W     = 2,
  parameter int COL_W    = 10,
  parameter int ADDR_W   = 13,
  parameter int AP_BIT   = 10,
  parameter int CNT_W    = 10,
  parameter int FIXED_BL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BA_W-1:0]   bank,
  input  logic [COL_W-1:0]  col,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic              cas_lat,
  input  logic              full_page,
  input  logic              auto_pre,
  input  logic              use_pre,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              dqm,
  output logic              capture,
  output logic              done,
  output logic              busy
);
  localparam int CYC_W = CNT_W + 2;
  localparam logic [CYC_W-1:0] BL = CYC_W'(FIXED_BL);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_PRE = 4'b0010;

  logic             active;
  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] n_q, cl_q;
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] col_q;
  logic             ap_q, term_q, pre_q;

  logic [CYC_W-1:0] req, n_d;
  logic             accept, is_rd, is_term;
  logic [ADDR_W-1:0] rd_addr;

  assign req = (word_cnt == '0) ? CYC_W'(1) : CYC_W'(word_cnt);

  always_comb begin
    if (full_page)      n_d = req;
    else if (auto_pre)  n_d = BL;
    else if (req < BL)  n_d = req;
    else                n_d = BL;
  end

  assign done    = active && (cyc == cl_q + n_q);
  assign busy    = active && !done;
  assign accept  = start && !busy;
  assign is_rd   = active && (cyc == '0);
  assign is_term = active && term_q && (cyc == n_q);
  assign capture = active && (cyc >= cl_q) && (cyc < cl_q + n_q);
  assign dqm     = !active;
  assign ba      = active ? bank_q : '0;

  always_comb begin
    rd_addr = '0;
    rd_addr[COL_W-1:0] = col_q;
    rd_addr[AP_BIT] = ap_q;
  end

  assign addr = is_rd ? rd_addr : '0;
  assign cmd  = is_rd   ? C_RD :
                is_term ? (pre_q ? C_PRE : C_BST) : C_NOP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cyc    <= '0;
      n_q    <= '0;
      cl_q   <= '0;
      bank_q <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      term_q <= 1'b0;
      pre_q  <= 1'b0;
    end else if (accept) begin
      active <= 1'b1;
      cyc    <= '0;
      n_q    <= n_d;
      cl_q   <= cas_lat ? CYC_W'(3) : CYC_W'(2);
      bank_q <= bank;
      col_q  <= col;
      ap_q   <= auto_pre && !full_page;
      term_q <= full_page || (n_d < BL);
      pre_q  <= use_pre;
    end else if (done) begin
      active <= 1'b0;
      cyc    <= '0;
    end else if (active) begin
      cyc    <= cyc + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_rd_trunc_chk.sv
module sdram_rd_trunc_chk #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              dqm,
  input logic              capture,
  input logic              done,
  input logic              busy
);
  assert_legal_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0111 || cmd == 4'b0101 || cmd == 4'b0110 || cmd == 4'b0010);

  assert_start_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> cmd == 4'b0101);

  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> cmd != 4'b0101);

  assert_capture_dqm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !dqm);

  assert_done_after_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(capture) && !capture && !busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_pre_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0010 |-> addr[AP_BIT] == 1'b0);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dqm |-> cmd == 4'b0111 && !capture && !done && !busy);
endmodule

bind sdram_rd_trunc sdram_rd_trunc_chk #(
  .BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .ba(ba),
  .dqm(dqm), .capture(capture), .done(done), .busy(busy)
);

// File: tb/sdram_rd_trunc_bench.sv
module sdram_rd_trunc_bench;
  localparam int BA_W = 2, COL_W = 10, ADDR_W = 13, AP_BIT = 10, CNT_W = 10, BL = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [BA_W-1:0] bank = '0;
  logic [COL_W-1:0] col = '0;
  logic [CNT_W-1:0] word_cnt = '0;
  logic cas_lat = 1'b0, full_page = 1'b0, auto_pre = 1'b0, use_pre = 1'b0;
  logic [3:0] cmd;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0] ba;
  logic dqm, capture, done, busy;

  int checks = 0, fails = 0, cycles = 0;
  int q_cmd[$], q_addr[$], q_cap[$], q_done[$];
  int cur_bank = 0;

  always #2.5 clk = ~clk;

  sdram_rd_trunc #(.BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
                   .CNT_W(CNT_W), .FIXED_BL(BL)) u_sdram_rd_trunc (
    .clk(clk), .rst_n(rst_n), .start(start), .bank(bank), .col(col),
    .word_cnt(word_cnt), .cas_lat(cas_lat), .full_page(full_page),
    .auto_pre(auto_pre), .use_pre(use_pre), .cmd(cmd), .addr(addr), .ba(ba),
    .dqm(dqm), .capture(capture), .done(done), .busy(busy));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: on acceptance, predict the whole sequence
  always @(posedge clk) begin
    if (rst_n && start && q_cmd.size() == 0) begin
      int n, neff, cl, term, ap;
      n    = (word_cnt == 0) ? 1 : int'(word_cnt);       // R3
      neff = full_page ? n : (auto_pre ? BL : (n < BL ? n : BL));
      term = (full_page || neff < BL) ? 1 : 0;             // R5, R7
      cl   = cas_lat ? 3 : 2;
      ap   = (auto_pre && !full_page) ? 1 : 0;
      cur_bank = int'(bank);
      for (int c = 0; c <= cl + neff; c++) begin
        if (c == 0) begin
          q_cmd.push_back(5); q_addr.push_back(int'(col) + (ap << AP_BIT));
        end else if (term == 1 && c == neff) begin
          q_cmd.push_back(use_pre ? 2 : 6); q_addr.push_back(0);
        end else begin
          q_cmd.push_back(7); q_addr.push_back(0);
        end
        q_cap.push_back((c >= cl && c < cl + neff) ? 1 : 0);
        q_done.push_back(c == cl + neff ? 1 : 0);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (q_cmd.size() == 0) begin
        chk("R1/R8", "idle cmd", int'(cmd), 7);
        chk("R1", "idle dqm", int'(dqm), 1);
        chk("R1", "idle capture", int'(capture), 0);
        chk("R1", "idle done", int'(done), 0);
        chk("R1", "idle busy", int'(busy), 0);
      end else begin
        chk("R2/R5/R6/R8", "cmd", int'(cmd), q_cmd[0]);
        chk("R2/R6", "addr", int'(addr), q_addr[0]);
        if (q_cmd[0] != 7) chk("R2/R6", "ba", int'(ba), cur_bank);
        chk("R4", "capture", int'(capture), q_cap[0]);
        chk("R10", "done", int'(done), q_done[0]);
        chk("R10", "busy", int'(busy), q_done[0] ? 0 : 1);
        chk("R9", "dqm", int'(dqm), 0);
        void'(q_cmd.pop_front()); void'(q_addr.pop_front());
        void'(q_cap.pop_front()); void'(q_done.pop_front());
      end
    end
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run(input int b, input int c, input int n, input bit cl3,
                     input bit fp, input bit ap, input bit pre);
    @(negedge clk);
    bank = BA_W'(b); col = COL_W'(c); word_cnt = CNT_W'(n);
    cas_lat = cl3; full_page = fp; auto_pre = ap; use_pre = pre; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q_cmd.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "reset cmd", int'(cmd), 7);
    chk("R1", "reset dqm", int'(dqm), 1);
    chk("R1", "reset busy", int'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(1, 16, 4, 0, 1, 0, 0);    // R5 full page CL2 BST
    run(2, 40, 4, 1, 1, 0, 0);    // R5 full page CL3 BST
    run(3, 7, 3, 1, 0, 0, 1);     // R6 fixed CL3 PRECHARGE
    run(0, 100, 10, 0, 0, 0, 0);  // R3 clamp to BL, no terminate
    run(1, 5, 3, 0, 0, 1, 0);     // R7 auto precharge runs full BL
    run(2, 9, 5, 1, 1, 1, 1);     // R2 A10 forced low in full page
    run(3, 1, 0, 0, 1, 0, 0);     // R3 zero counts as one
    run(0, 2, 1, 1, 0, 0, 0);     // R5 N=1 CL3, terminate before data
    run(1, 3, 20, 1, 1, 0, 1);    // R6 long full page with PRECHARGE
    // R11: start held high across busy and into done
    @(negedge clk);
    bank = 2'd2; col = 10'd33; word_cnt = 10'd2; cas_lat = 1'b0;
    full_page = 1'b0; auto_pre = 1'b0; use_pre = 1'b0; start = 1'b1;
    repeat (12) @(negedge clk);
    start = 1'b0;
    while (q_cmd.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule